// File: doc/BRIEF.md
# Byte FIFO with Fill-Level Threshold Signalling

This block is a byte-wide first-in first-out buffer placed between a host access port and a radio packet engine. The direction input picks who writes and who reads. In transmit direction the host loads bytes and the engine drains them. In receive direction the engine loads bytes and the host drains them. Pushes and pops from the other two port sides are ignored. The usable depth is chosen at run time from four sizes by a 2-bit select, up to 64 bytes.

A 6-bit threshold field is compared with the live fill count to produce three signals. The effective threshold is the field value plus one. In receive direction a request tells the host to fetch bytes once enough have arrived. In transmit direction a request tells the host there is room to add more bytes. A transmit-active level tells the engine to start sending once enough bytes are queued, and to stop when the buffer runs dry. A write that finds the buffer full is lost and leaves a sticky overflow flag. A clear strobe empties the buffer and drops that flag.

Top module: `bytefifo_top`

## Requirements
- R1: Usable depth is 16 × (depth_sel + 1) bytes, so 0, 1, 2 and 3 give 16, 32, 48 and 64. `full` is 1 exactly when fill_count equals that depth.
- R2: Bytes leave in the order they were accepted. While the buffer is not empty, `rd_data` shows the oldest stored byte.
- R3: With tx_mode=1, host_push (data host_wdata) writes and eng_pop reads, while host_pop and eng_push have no effect. With tx_mode=0, eng_push (data eng_wdata) writes and host_pop reads, while eng_pop and host_push have no effect.
- R4: fill_count changes on the same clock edge as an accepted push or pop. A push and a pop in the same cycle leave it unchanged, and this holds even when the buffer is full.
- R5: A push into a full buffer with no pop in the same cycle is dropped. Count and contents stay as they were, and `overflow` becomes 1.
- R6: `overflow` stays 1 until reset or a fifo_clear strobe. fifo_clear empties the buffer on the next edge.
- R7: A pop from an empty buffer has no effect, and fill_count stays 0.
- R8: rx_irq is 1 exactly when tx_mode=0 and fill_count ≥ thresh + 1.
- R9: tx_irq is 1 exactly when tx_mode=1 and fill_count ≤ thresh.
- R10: In transmit direction, tx_active rises on the edge where fill_count becomes ≥ thresh + 1. It stays high while bytes remain, even below the threshold, and falls on the edge where fill_count reaches 0. It also falls when tx_mode goes to 0 or on fifo_clear.
- R11: After reset the buffer is empty (fill_count 0, empty 1), and full, overflow and tx_active are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_mode | input | 1 | 1 = transmit direction, 0 = receive direction |
| depth_sel | input | 2 | Depth select, 16 × (value + 1) bytes |
| thresh | input | 6 | Threshold field; effective threshold is value + 1 |
| fifo_clear | input | 1 | Single-cycle flush strobe |
| host_push | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_pop | input | 1 | Host read strobe |
| eng_push | input | 1 | Engine write strobe |
| eng_wdata | input | 8 | Engine write byte |
| eng_pop | input | 1 | Engine read strobe |
| rd_data | output | 8 | Oldest stored byte |
| fill_count | output | 7 | Bytes currently stored |
| full | output | 1 | Count equals selected depth |
| empty | output | 1 | Count is zero |
| overflow | output | 1 | Sticky dropped-write flag |
| rx_irq | output | 1 | Receive fetch request |
| tx_irq | output | 1 | Transmit refill request |
| tx_active | output | 1 | Engine may transmit |

## Verification
The bench hits the threshold edges from both sides: one byte below the effective threshold and exactly at it. A design that compares with the raw field, or uses the same direction for receive and transmit, flips rx_irq, tx_irq or tx_active one byte early or late. The bench drives a simultaneous push and pop while full. A design that rejects that push shows a count of 15 and raises overflow. The bench reads data out across the pointer wrap and after a dropped write, which catches wrong ordering or a dropped byte that still got stored. It drains the transmit side below the threshold, where a design that drops tx_active too early stops sending. It also sends strobes from the inactive port sides, which a design that ignores the direction would accept.

// File: rtl/bytefifo_pkg.sv
package bytefifo_pkg;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  // Depth in entries for a given select code and step size
  function automatic int unsigned depth_for(input int unsigned sel, input int unsigned step);
    return step * (sel + 1);
  endfunction

endpackage

// File: rtl/bytefifo_rst_sync.sv
module bytefifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_sync_n = stg_q[STAGES-1];
endmodule

// File: rtl/bytefifo_store.sv
module bytefifo_store #(
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 64,
  parameter int PTR_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_ptr];
endmodule

// File: rtl/bytefifo_ctrl.sv
module bytefifo_ctrl #(
  parameter int SEL_W = 2,
  parameter int STEP  = 16,
  parameter int PTR_W = 6,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] depth_sel,
  input  logic             clear,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             full,
  output logic             empty,
  output logic             overflow
);
  logic [CNT_W-1:0] depth;
  logic [PTR_W-1:0] last_idx;
  logic             push_ok, pop_ok, drop;
  logic [PTR_W-1:0] wr_ptr_d, rd_ptr_d;
  logic             ovf_d;
  logic             ptr_en, ovf_en;

  assign depth    = CNT_W'(bytefifo_pkg::depth_for(int'(depth_sel), STEP));
  assign last_idx = PTR_W'(depth - CNT_W'(1));
  assign full     = (count == depth);
  assign empty    = (count == '0);

  always_comb begin
    pop_ok  = pop_req && !empty;
    push_ok = push_req && (!full || pop_ok);
    drop    = push_req && !push_ok;
    wr_en   = push_ok && !clear;

    count_nxt = count;
    wr_ptr_d  = wr_ptr;
    rd_ptr_d  = rd_ptr;
    ovf_d     = overflow;
    if (clear) begin
      count_nxt = '0;
      wr_ptr_d  = '0;
      rd_ptr_d  = '0;
      ovf_d     = 1'b0;
    end else begin
      if (push_ok && !pop_ok)      count_nxt = count + CNT_W'(1);
      else if (pop_ok && !push_ok) count_nxt = count - CNT_W'(1);
      if (push_ok) wr_ptr_d = (wr_ptr == last_idx) ? '0 : wr_ptr + PTR_W'(1);
      if (pop_ok)  rd_ptr_d = (rd_ptr == last_idx) ? '0 : rd_ptr + PTR_W'(1);
      if (drop)    ovf_d    = 1'b1;
    end
  end

  assign ptr_en = clear || push_ok || pop_ok;
  assign ovf_en = clear || drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (ptr_en) begin
      count  <= count_nxt;
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      overflow <= 1'b0;
    else if (ovf_en) overflow <= ovf_d;
  end
endmodule

// File: rtl/bytefifo_thresh.sv
module bytefifo_thresh #(
  parameter int THR_W = 6,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_mode,
  input  logic             clear,
  input  logic [THR_W-1:0] thresh,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] count_nxt,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             tx_active
);
  logic [CNT_W-1:0] thr_raw, thr_eff;
  logic             act_d;

  assign thr_raw = CNT_W'(thresh);
  assign thr_eff = thr_raw + CNT_W'(1);

  assign rx_irq = (tx_mode == bytefifo_pkg::DIR_RX) && (count >= thr_eff);
  assign tx_irq = (tx_mode == bytefifo_pkg::DIR_TX) && (count <= thr_raw);

  always_comb begin
    if (clear || (tx_mode != bytefifo_pkg::DIR_TX)) act_d = 1'b0;
    else if (tx_active)                              act_d = (count_nxt != '0);
    else                                             act_d = (count_nxt >= thr_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_active <= 1'b0;
    else        tx_active <= act_d;
  end
endmodule

// File: rtl/bytefifo_top.sv
module bytefifo_top #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  parameter int THR_W  = 6,
  parameter int STEP   = 16,
  localparam int MAX_DEPTH = STEP * (2 ** SEL_W),
  localparam int PTR_W     = $clog2(MAX_DEPTH),
  localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_mode,
  input  logic [SEL_W-1:0]  depth_sel,
  input  logic [THR_W-1:0]  thresh,
  input  logic              fifo_clear,
  input  logic              host_push,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_pop,
  input  logic              eng_push,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  fill_count,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              tx_active
);
  logic              rst_int_n;
  logic              push_req, pop_req, wr_en;
  logic [DATA_W-1:0] wdata;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count_nxt;

  bytefifo_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  // Direction routing: transmit loads from host, receive loads from engine
  always_comb begin
    if (tx_mode == bytefifo_pkg::DIR_TX) begin
      push_req = host_push;
      wdata    = host_wdata;
      pop_req  = eng_pop;
    end else begin
      push_req = eng_push;
      wdata    = eng_wdata;
      pop_req  = host_pop;
    end
  end

  bytefifo_ctrl #(.SEL_W(SEL_W), .STEP(STEP), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .depth_sel(depth_sel), .clear(fifo_clear),
    .push_req(push_req), .pop_req(pop_req), .wr_en(wr_en),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(fill_count), .count_nxt(count_nxt),
    .full(full), .empty(empty), .overflow(overflow)
  );

  bytefifo_store #(.DATA_W(DATA_W), .ENTRIES(MAX_DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wdata),
    .rd_ptr(rd_ptr), .rd_data(rd_data)
  );

  bytefifo_thresh #(.THR_W(THR_W), .CNT_W(CNT_W)) u_thr (
    .clk(clk), .rst_n(rst_int_n), .tx_mode(tx_mode), .clear(fifo_clear),
    .thresh(thresh), .count(fill_count), .count_nxt(count_nxt),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .tx_active(tx_active)
  );
endmodule

// File: rtl/bytefifo_chk.sv
module bytefifo_chk #(
  parameter int SEL_W = 2,
  parameter int THR_W = 6,
  parameter int STEP  = 16,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_mode,
  input logic [SEL_W-1:0] depth_sel,
  input logic [THR_W-1:0] thresh,
  input logic             fifo_clear,
  input logic             host_push,
  input logic             host_pop,
  input logic             eng_push,
  input logic             eng_pop,
  input logic [CNT_W-1:0] fill_count,
  input logic             full,
  input logic             empty,
  input logic             overflow,
  input logic             rx_irq,
  input logic             tx_irq,
  input logic             tx_active
);
  // R1
  full_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (fill_count == CNT_W'(STEP) * (CNT_W'(depth_sel) + CNT_W'(1))));

  // R5
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && host_push && full && !eng_pop && !fifo_clear)
    |=> (overflow && fill_count == $past(fill_count)));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !fifo_clear) |=> overflow);

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !tx_mode && host_pop && !eng_push && !fifo_clear) |=> empty);

  // R4
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode && eng_push && host_pop && !empty && !fifo_clear)
    |=> (fill_count == $past(fill_count)));

  // R8
  rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (!tx_mode && fill_count > CNT_W'(thresh)));

  // R9
  tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (tx_mode && !rx_irq));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && tx_mode && !fifo_clear && fill_count > CNT_W'(1)) |=> tx_active);
endmodule

bind bytefifo_top bytefifo_chk #(
  .SEL_W(SEL_W), .THR_W(THR_W), .STEP(STEP), .CNT_W(CNT_W)
) u_bytefifo_chk (
  .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .depth_sel(depth_sel),
  .thresh(thresh), .fifo_clear(fifo_clear), .host_push(host_push),
  .host_pop(host_pop), .eng_push(eng_push), .eng_pop(eng_pop),
  .fill_count(fill_count), .full(full), .empty(empty), .overflow(overflow),
  .rx_irq(rx_irq), .tx_irq(tx_irq), .tx_active(tx_active)
);

// File: tb/test_bytefifo_top.sv
`timescale 1ns/1ps
module test_bytefifo_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_mode;
  logic [1:0] depth_sel;
  logic [5:0] thresh;
  logic       fifo_clear, host_push, host_pop, eng_push, eng_pop;
  logic [7:0] host_wdata, eng_wdata, rd_data;
  logic [6:0] fill_count;
  logic       full, empty, overflow, rx_irq, tx_irq, tx_active;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  bytefifo_top i_bytefifo_top (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .depth_sel(depth_sel),
    .thresh(thresh), .fifo_clear(fifo_clear), .host_push(host_push),
    .host_wdata(host_wdata), .host_pop(host_pop), .eng_push(eng_push),
    .eng_wdata(eng_wdata), .eng_pop(eng_pop), .rd_data(rd_data),
    .fill_count(fill_count), .full(full), .empty(empty), .overflow(overflow),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .tx_active(tx_active)
  );

  typedef struct packed {
    logic       m, hp, hpo, ep, epo;
    logic [7:0] wd;
    logic [6:0] cnt;
    logic       crd;
    logic [7:0] rd;
  } vec_t;

  // Routing, ordering and simultaneous push/pop (R2, R3, R4, R7)
  localparam vec_t VEC [10] = '{
    '{1'b1,1'b1,1'b0,1'b0,1'b0,8'hA1,7'd1,1'b1,8'hA1},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,8'hB2,7'd2,1'b1,8'hA1},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,8'h00,7'd2,1'b1,8'hA1},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,8'hC3,7'd2,1'b1,8'hA1},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,8'hC3,7'd2,1'b1,8'hB2},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,7'd1,1'b1,8'hC3},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,8'hD4,7'd2,1'b1,8'hC3},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,7'd1,1'b1,8'hD4},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,7'd1,1'b1,8'hD4},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,7'd0,1'b0,8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc1(input logic m, hp, hpo, ep, epo, input logic [7:0] wd, input logic clr);
    @(negedge clk);
    tx_mode = m; host_push = hp; host_pop = hpo; eng_push = ep; eng_pop = epo;
    host_wdata = wd; eng_wdata = wd; fifo_clear = clr;
    @(posedge clk);
    #1;
    host_push = 0; host_pop = 0; eng_push = 0; eng_pop = 0; fifo_clear = 0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog R11 actual=%0d expected<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tx_mode = 0; depth_sel = 0; thresh = 6'd3;
    fifo_clear = 0; host_push = 0; host_pop = 0; eng_push = 0; eng_pop = 0;
    host_wdata = 0; eng_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 count", fill_count, 0);
    chk("R11 empty", empty, 1);
    chk("R11 full", full, 0);
    chk("R11 overflow", overflow, 0);
    chk("R11 tx_active", tx_active, 0);

    // Vector table: R2 R3 R4 R7
    foreach (VEC[i]) begin
      cyc1(VEC[i].m, VEC[i].hp, VEC[i].hpo, VEC[i].ep, VEC[i].epo, VEC[i].wd, 1'b0);
      chk($sformatf("R3 R4 vec%0d count", i), fill_count, VEC[i].cnt);
      if (VEC[i].crd) chk($sformatf("R2 vec%0d rd_data", i), rd_data, VEC[i].rd);
    end

    // R1 depth 16, R5 overflow, R4 full push+pop, R2 order across wrap
    for (int i = 0; i < 16; i++) cyc1(0, 0, 0, 1, 0, 8'h10 + 8'(i), 0);
    chk("R1 count at 16", fill_count, 16);
    chk("R1 full at 16", full, 1);
    chk("R2 head", rd_data, 8'h10);
    cyc1(0, 0, 0, 1, 0, 8'hFF, 0);
    chk("R5 count after drop", fill_count, 16);
    chk("R5 overflow", overflow, 1);
    cyc1(0, 0, 1, 1, 0, 8'h55, 0);
    chk("R4 full push+pop count", fill_count, 16);
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R2 R5 order %0d", i), rd_data, (i < 15) ? 8'h11 + 8'(i) : 8'h55);
      cyc1(0, 0, 1, 0, 0, 8'h00, 0);
    end
    chk("R7 empty", empty, 1);
    cyc1(0, 0, 1, 0, 0, 8'h00, 0);
    chk("R7 pop on empty count", fill_count, 0);
    chk("R6 overflow sticky", overflow, 1);
    cyc1(0, 0, 0, 0, 0, 8'h00, 1);
    chk("R6 overflow cleared", overflow, 0);

    // R1 depth 64 with R8 threshold 31 -> 32
    depth_sel = 2'd3; thresh = 6'd31;
    for (int i = 1; i <= 64; i++) begin
      cyc1(0, 0, 0, 1, 0, 8'(i), 0);
      if (i == 31) chk("R8 rx_irq below", rx_irq, 0);
      if (i == 32) chk("R8 rx_irq at", rx_irq, 1);
      if (i == 32) chk("R9 tx_irq off in rx", tx_irq, 0);
      if (i == 48) chk("R1 not full at 48", full, 0);
    end
    chk("R1 full at 64", full, 1);
    cyc1(0, 0, 0, 1, 0, 8'hEE, 0);
    chk("R5 count at 64 drop", fill_count, 64);
    cyc1(0, 0, 0, 0, 0, 8'h00, 1);
    chk("R6 clear empties", fill_count, 0);

    // Transmit thresholds R9 R10, depth 16, thresh 3 -> 4
    depth_sel = 2'd0; thresh = 6'd3;
    cyc1(1, 0, 0, 0, 0, 8'h00, 0);
    chk("R9 tx_irq empty", tx_irq, 1);
    for (int i = 0; i < 3; i++) cyc1(1, 1, 0, 0, 0, 8'h20 + 8'(i), 0);
    chk("R9 tx_irq at 3", tx_irq, 1);
    chk("R10 idle below", tx_active, 0);
    cyc1(1, 1, 0, 0, 0, 8'h23, 0);
    chk("R9 tx_irq at 4", tx_irq, 0);
    chk("R10 start at 4", tx_active, 1);
    cyc1(1, 0, 0, 0, 1, 8'h00, 0);
    chk("R10 hold at 3", tx_active, 1);
    chk("R9 tx_irq back", tx_irq, 1);
    cyc1(1, 0, 0, 0, 1, 8'h00, 0);
    cyc1(1, 0, 0, 0, 1, 8'h00, 0);
    chk("R10 hold at 1", tx_active, 1);
    cyc1(1, 0, 0, 0, 1, 8'h00, 0);
    chk("R10 stop at 0", tx_active, 0);
    for (int i = 0; i < 4; i++) cyc1(1, 1, 0, 0, 0, 8'h30, 0);
    chk("R10 restart", tx_active, 1);
    cyc1(0, 0, 0, 0, 0, 8'h00, 0);
    chk("R10 mode exit", tx_active, 0);
    chk("R8 rx_irq in rx", rx_irq, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule